// File: doc/BRIEF.md
# LDPC Decode Iteration Scheduler

This block is the control unit of a partially parallel LDPC decoder. The code's bit nodes and check nodes are each split into `NUM_GROUPS` groups, and the node arrays process one group per clock. The scheduler steps through the groups, drives a group index and an enable strobe to each array, counts iterations and decides when decoding ends. It runs the two arrays in one of two schedules. In the serial schedule every bit-node group runs, and then every check-node group runs. In the overlapped schedule each check-node group trails its bit-node group by exactly one cycle, so both arrays are busy together for most of the iteration.

A one-cycle start pulse begins a decode and also captures the schedule choice. The external syndrome checker supplies a single "all parity checks satisfied" flag. The scheduler samples that flag in the last cycle of every iteration. Decoding ends when the flag is high or when `MAX_ITER` iterations have completed. At that point the block raises a one-cycle done pulse and reports a success flag and the number of iterations used. The node arithmetic and the syndrome computation lie outside this block.

Top module: `ldpc_iter_sched`

## Requirements
- R1: While reset is held, and afterwards until the first accepted start, `busy_o`, `done_o`, both enable strobes, `success_o` and `iters_used_o` are all zero.
- R2: In the serial schedule (`overlap_i` = 0 at start), iteration cycle s for s < G enables bit-node group s alone. Cycle G+k enables check-node group k alone. An iteration lasts 2G cycles, and the two strobes are never high together.
- R3: In the overlapped schedule (`overlap_i` = 1 at start), iteration cycle s enables bit-node group s for s < G and check-node group s-1 for 1 ≤ s ≤ G. An iteration lasts G+1 cycles, and both strobes are high in cycles 1 to G-1.
- R4: When decoding continues, the next iteration's bit-node group 0 is enabled in the cycle right after the previous iteration's last check-node group. No cycle is lost between iterations.
- R5: `syn_zero_i` is sampled only in the last cycle of each iteration. If it is high there, decoding stops after that iteration with `success_o` = 1.
- R6: If the syndrome flag is low at the end of iteration `MAX_ITER`, decoding stops with `success_o` = 0 and `iters_used_o` = `MAX_ITER`. At most `MAX_ITER` iterations ever run.
- R7: `done_o` is high for exactly one cycle, the cycle after the final iteration's last cycle, and `busy_o` is already low in that cycle. `success_o` and `iters_used_o` carry the result from that cycle on and hold it until the next accepted start, which clears them.
- R8: A start pulse that arrives while `busy_o` is high is ignored. `overlap_i` is sampled only at an accepted start, so toggling it during a decode changes neither the schedule nor the run length.
- R9: With G = 1 an iteration takes 2 cycles in either schedule: the bit-node strobe is high in the first cycle and the check-node strobe in the second.
- R10: In the cycle after an accepted start, `busy_o` is high and bit-node group 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| overlap_i | input | 1 | Schedule select captured at start: 1 overlapped, 0 serial |
| syn_zero_i | input | 1 | All parity checks satisfied by the current hard decisions |
| busy_o | output | 1 | Decode in progress |
| bn_en_o | output | 1 | Bit-node group strobe |
| bn_grp_o | output | GRP_W | Bit-node group index, zero when the strobe is low |
| cn_en_o | output | 1 | Check-node group strobe |
| cn_grp_o | output | GRP_W | Check-node group index, zero when the strobe is low |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| success_o | output | 1 | Last decode ended on a satisfied syndrome |
| iters_used_o | output | ITER_W | Iterations run by the last decode |

## Verification
A wrong step count inside an iteration shows up in the first iteration as a misplaced strobe or group index. It also shows up at the end of the decode as a busy window whose length is not a whole multiple of the iteration length. A wrong iteration count, or a stop test that samples the syndrome flag in the wrong cycle, changes either the run length or the `iters_used_o`/`success_o` pair reported with `done_o`. Both are visible one cycle after the final iteration. If a start were accepted during a decode, or the schedule selection leaked in mid-decode, the strobe pattern would change in the very next iteration.

// File: rtl/ldpc_sched_pkg.sv
package ldpc_sched_pkg;

  typedef enum logic {
    SCHED_SERIAL  = 1'b0,
    SCHED_OVERLAP = 1'b1
  } sched_mode_e;

  // Length of one iteration in clocks for a given group count and schedule.
  function automatic int cycles_per_iter(input int groups, input sched_mode_e m);
    return (m == SCHED_OVERLAP) ? groups + 1 : 2 * groups;
  endfunction

  // A bit-node group is active in the first `groups` cycles in both schedules.
  function automatic logic bn_slot(input int step, input int groups);
    return step < groups;
  endfunction

  // Check-node activity: one cycle behind the bit nodes when overlapped,
  // after all bit nodes when serial.
  function automatic logic cn_slot(input int step, input int groups, input sched_mode_e m);
    if (m == SCHED_OVERLAP)
      return (step >= 1) && (step <= groups);
    return (step >= groups) && (step < 2 * groups);
  endfunction

  function automatic int cn_slot_index(input int step, input int groups, input sched_mode_e m);
    return (m == SCHED_OVERLAP) ? step - 1 : step - groups;
  endfunction

endpackage

// File: rtl/ldpc_grp_seq.sv
module ldpc_grp_seq
  import ldpc_sched_pkg::*;
#(
  parameter int G      = 8,
  parameter int GRP_W  = 3,
  localparam int STEP_W = (2 * G > 1) ? $clog2(2 * G) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  sched_mode_e      mode_i,
  output logic             bn_en_o,
  output logic [GRP_W-1:0] bn_grp_o,
  output logic             cn_en_o,
  output logic [GRP_W-1:0] cn_grp_o,
  output logic             last_o
);

  logic [STEP_W-1:0] step_q;
  int                step_i;
  int                len_i;

  assign step_i = int'(step_q);
  assign len_i  = cycles_per_iter(G, mode_i);
  assign last_o = run_i && (step_i == len_i - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (!run_i || last_o) begin
      step_q <= '0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  always_comb begin
    bn_en_o  = run_i && bn_slot(step_i, G);
    cn_en_o  = run_i && cn_slot(step_i, G, mode_i);
    bn_grp_o = bn_en_o ? GRP_W'(step_i) : '0;
    cn_grp_o = cn_en_o ? GRP_W'(cn_slot_index(step_i, G, mode_i)) : '0;
  end

  // R2
  serial_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == SCHED_SERIAL) |-> !(bn_en_o && cn_en_o));

  // R3
  overlap_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == SCHED_OVERLAP && cn_en_o) |->
      ($past(bn_en_o) && cn_grp_o == $past(bn_grp_o)));

  // R2
  bn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bn_en_o && bn_grp_o != GRP_W'(G - 1)) |=>
      (bn_en_o && bn_grp_o == $past(bn_grp_o) + GRP_W'(1)));

endmodule

// File: rtl/ldpc_iter_ctr.sv
module ldpc_iter_ctr #(
  parameter int MAX_ITER = 10,
  parameter int ITER_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              syn_zero_i,
  output logic              busy_o,
  output logic [ITER_W-1:0] iter_o,
  output logic              finish_o,
  output logic              finish_ok_o
);

  logic              busy_q;
  logic [ITER_W-1:0] iter_q;
  logic              at_limit;

  assign at_limit    = (iter_q == ITER_W'(MAX_ITER));
  assign finish_o    = busy_q && last_i && (syn_zero_i || at_limit);
  assign finish_ok_o = syn_zero_i;
  assign busy_o      = busy_q;
  assign iter_o      = iter_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iter_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      iter_q <= ITER_W'(1);
    end else if (finish_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && last_i) begin
      iter_q <= iter_q + ITER_W'(1);
    end
  end

  // R6
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (iter_q >= ITER_W'(1) && iter_q <= ITER_W'(MAX_ITER)));

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(last_i));

endmodule

// File: rtl/ldpc_done_stat.sv
module ldpc_done_stat #(
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              finish_i,
  input  logic              ok_i,
  input  logic [ITER_W-1:0] iter_i,
  output logic              done_o,
  output logic              success_o,
  output logic [ITER_W-1:0] iters_o
);

  logic              done_q;
  logic              success_q;
  logic [ITER_W-1:0] iters_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      success_q <= 1'b0;
      iters_q   <= '0;
    end else if (start_i) begin
      done_q    <= 1'b0;
      success_q <= 1'b0;
      iters_q   <= '0;
    end else begin
      done_q <= finish_i;
      if (finish_i) begin
        success_q <= ok_i;
        iters_q   <= iter_i;
      end
    end
  end

  assign done_o    = done_q;
  assign success_o = success_q;
  assign iters_o   = iters_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !finish_i) |=> ($stable(success_q) && $stable(iters_q)));

endmodule

// File: rtl/ldpc_iter_sched.sv
module ldpc_iter_sched
  import ldpc_sched_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int MAX_ITER   = 10,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              overlap_i,
  input  logic              syn_zero_i,
  output logic              busy_o,
  output logic              bn_en_o,
  output logic [GRP_W-1:0]  bn_grp_o,
  output logic              cn_en_o,
  output logic [GRP_W-1:0]  cn_grp_o,
  output logic              done_o,
  output logic              success_o,
  output logic [ITER_W-1:0] iters_used_o
);

  // Named internal events.
  logic              start_acc;
  logic              iter_last;
  logic              stop_evt;
  logic              stop_ok;
  logic              busy_w;
  logic [ITER_W-1:0] iter_w;
  sched_mode_e       mode_q;

  assign start_acc = start_i && !busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SCHED_SERIAL;
    end else if (start_acc) begin
      mode_q <= overlap_i ? SCHED_OVERLAP : SCHED_SERIAL;
    end
  end

  ldpc_grp_seq #(
    .G     (NUM_GROUPS),
    .GRP_W (GRP_W)
  ) u_grp_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy_w),
    .mode_i   (mode_q),
    .bn_en_o  (bn_en_o),
    .bn_grp_o (bn_grp_o),
    .cn_en_o  (cn_en_o),
    .cn_grp_o (cn_grp_o),
    .last_o   (iter_last)
  );

  ldpc_iter_ctr #(
    .MAX_ITER (MAX_ITER),
    .ITER_W   (ITER_W)
  ) u_iter_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_acc),
    .last_i      (iter_last),
    .syn_zero_i  (syn_zero_i),
    .busy_o      (busy_w),
    .iter_o      (iter_w),
    .finish_o    (stop_evt),
    .finish_ok_o (stop_ok)
  );

  ldpc_done_stat #(
    .ITER_W (ITER_W)
  ) u_done_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_acc),
    .finish_i  (stop_evt),
    .ok_i      (stop_ok),
    .iter_i    (iter_w),
    .done_o    (done_o),
    .success_o (success_o),
    .iters_o   (iters_used_o)
  );

  assign busy_o = busy_w;

  // R10
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy_o && bn_en_o && bn_grp_o == '0));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> (!busy_w || $stable(mode_q)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (!bn_en_o && !cn_en_o));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_w);

endmodule

// File: tb/test_ldpc_iter_sched.sv
module test_ldpc_iter_sched;

  localparam int NG  = 4;
  localparam int MI  = 3;
  localparam int GW  = 2;
  localparam int IW  = 2;

  // columns: overlap, stop_at_iter (0 = never), glitch cycle (-1 none), exp success, exp iters
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{1, 1, -1, 1, 1},
    '{0, 2, -1, 1, 2},
    '{1, 0, -1, 0, 3},
    '{0, 0, -1, 0, 3},
    '{1, 3, -1, 1, 3},
    '{0, 1,  3, 1, 1},
    '{1, 2,  6, 1, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, overlap_i = 1'b0, syn_zero_i = 1'b0;
  logic busy_o, bn_en_o, cn_en_o, done_o, success_o;
  logic [GW-1:0] bn_grp_o, cn_grp_o;
  logic [IW-1:0] iters_used_o;

  logic st2 = 1'b0, ov2 = 1'b0;
  logic b2_busy, b2_bn, b2_cn, b2_done, b2_ok;
  logic [0:0] b2_bg, b2_cg;
  logic [1:0] b2_it;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ldpc_iter_sched #(.NUM_GROUPS(NG), .MAX_ITER(MI)) i_ldpc_iter_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .overlap_i(overlap_i),
    .syn_zero_i(syn_zero_i), .busy_o(busy_o), .bn_en_o(bn_en_o),
    .bn_grp_o(bn_grp_o), .cn_en_o(cn_en_o), .cn_grp_o(cn_grp_o),
    .done_o(done_o), .success_o(success_o), .iters_used_o(iters_used_o));

  ldpc_iter_sched #(.NUM_GROUPS(1), .MAX_ITER(2)) i_ldpc_iter_sched_g1 (
    .clk(clk), .rst_n(rst_n), .start_i(st2), .overlap_i(ov2),
    .syn_zero_i(1'b0), .busy_o(b2_busy), .bn_en_o(b2_bn),
    .bn_grp_o(b2_bg), .cn_en_o(b2_cn), .cn_grp_o(b2_cg),
    .done_o(b2_done), .success_o(b2_ok), .iters_used_o(b2_it));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int ov, input int stop_at, input int glitch,
                         input int exp_ok, input int exp_it);
    int it, s, len, cnt, bad;
    bit eb, ec;
    int eg, ecg;
    string rq;
    len = ov ? NG + 1 : 2 * NG;
    rq  = ov ? "R3" : "R2";
    it = 1; s = 0; cnt = 0; bad = 0;
    start_i = 1'b1; overlap_i = ov[0]; syn_zero_i = (stop_at == 1);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && bn_en_o && bn_grp_o == 0, "R10", int'(bn_en_o), 1);
    while (busy_o && cnt < 200) begin
      eb  = (s < NG);
      ec  = ov ? (s >= 1 && s <= NG) : (s >= NG);
      eg  = eb ? s : 0;
      ecg = ec ? (ov ? s - 1 : s - NG) : 0;
      if (bn_en_o != eb || cn_en_o != ec || int'(bn_grp_o) != eg || int'(cn_grp_o) != ecg)
        bad++;
      syn_zero_i = (it == stop_at);
      if (cnt == glitch) begin
        start_i = 1'b1; overlap_i = ~ov[0];
      end else begin
        start_i = 1'b0; overlap_i = ov[0];
      end
      cnt++;
      s++;
      if (s == len) begin s = 0; it++; end
      @(negedge clk);
    end
    start_i = 1'b0; syn_zero_i = 1'b0;
    check(bad == 0, rq, bad, 0);
    check(cnt == exp_it * len, (glitch >= 0) ? "R8" : "R4", cnt, exp_it * len);
    check(done_o == 1'b1, "R7", int'(done_o), 1);
    check(success_o == exp_ok[0], exp_ok ? "R5" : "R6", int'(success_o), exp_ok);
    check(int'(iters_used_o) == exp_it, "R6", int'(iters_used_o), exp_it);
    @(negedge clk);
    check(done_o == 1'b0 && success_o == exp_ok[0] && int'(iters_used_o) == exp_it,
          "R7", int'(done_o), 0);
  endtask

  task automatic run_g1(input bit ov);
    int cnt, bad;
    st2 = 1'b1; ov2 = ov;
    @(negedge clk);
    st2 = 1'b0;
    cnt = 0; bad = 0;
    while (b2_busy && cnt < 50) begin
      if (b2_bn != (cnt % 2 == 0) || b2_cn != (cnt % 2 == 1) || b2_bg != 0 || b2_cg != 0)
        bad++;
      cnt++;
      @(negedge clk);
    end
    check(bad == 0, "R9", bad, 0);
    check(cnt == 4, "R9", cnt, 4);
    check(b2_done && !b2_ok && b2_it == 2'd2, "R9", int'(b2_it), 2);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: during reset
    check(!busy_o && !done_o && !bn_en_o && !cn_en_o, "R1", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && !bn_en_o && !cn_en_o, "R1", int'(bn_en_o), 0);
    check(!success_o && iters_used_o == 0, "R1", int'(iters_used_o), 0);
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      repeat (2) @(negedge clk);
    end
    // R7: accepted start clears status
    start_i = 1'b1; overlap_i = 1'b1; syn_zero_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(!success_o && iters_used_o == 0, "R7", int'(iters_used_o), 0);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    run_g1(1'b0);
    run_g1(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule